// File: doc/BRIEF.md
# USB Pipe Packet Buffer Port

This block is the processor-side access port of a 64-byte packet buffer that serves one USB pipe. The buffer is owned either by the CPU or by the serial interface engine (SIE), and it changes hands once per packet. In the transmit direction the CPU writes 8-bit or 16-bit data into the buffer. The packet passes to the SIE when the buffer is full, when the configured maximum packet size is reached, or when the CPU commits a short packet. In the receive direction the SIE fills the buffer and hands it to the CPU with a length. The CPU reads the packet out through the same port, and the buffer goes back to the SIE once the whole packet has been read or when the CPU clears it.

The CPU works the port through single-cycle command strobes: commit, clear and rewind. It also sees a length output and an ownership flag. The SIE side is a plain handshake. In transmit it reads bytes by address and returns the buffer with a done pulse. In receive it writes bytes by address and ends the packet with a length. A received-packet counter compares the number of received packets with a loaded target.

Top module: `pkt_buf_port`

## Requirements
- R1: After reset, with `dirTx` high, the CPU owns an empty buffer: `cpuOwns`=1, `dataLen`=0, `sieTxReady`=0, `sieRxReady`=0 and `trnCount`=0.
- R2: In transmit, each accepted write with `wide`=0 stores `cpuWrData[7:0]` at the next byte and adds 1 to `dataLen`. A write with `wide`=1 stores bits [7:0] at the lower address and bits [15:8] at the next address, and adds 2.
- R3: In transmit, the write that brings the count to the limit hands the packet over on the next cycle (`cpuOwns`=0, `sieTxReady`=1, `sieTxLen`=limit). The limit is 64 when `contMode`=1 and `maxPkt` when `contMode`=0. `dataLen` never exceeds 64.
- R4: A `cmdCommit` pulse in transmit while the CPU owns the buffer hands over a short packet whose `sieTxLen` equals the bytes written so far.
- R5: A `cmdClear` pulse in transmit empties the buffer (`dataLen`=0) and leaves it with the CPU. A `cmdCommit` that follows hands over a packet of length 0.
- R6: While the SIE holds a transmit packet, `sieRdData` shows the byte at `sieRdAddr`. A `sieTxDone` pulse returns an empty buffer to the CPU.
- R7: In receive, `sieRxWrEn` stores `sieRxData` at `sieRxAddr` while `sieRxReady` is high. A `sieRxEnd` pulse hands the packet to the CPU with `dataLen`=`sieRxLen`. `cpuRdData` shows the byte at the read pointer in bits [7:0] and, when `wide`=1, the next byte in bits [15:8]. A byte lane past the end of the packet reads 0. Each `cpuRdEn` advances the pointer by 1 or 2.
- R8: With `rxAutoRelease`=1, the read that consumes the last byte returns the buffer to the SIE (`cpuOwns`=0, `sieRxReady`=1). With `rxAutoRelease`=0, the CPU keeps the buffer after full readout until it pulses `cmdClear`.
- R9: A received packet of length 0 stays with the CPU whatever `cpuRdEn` does, and `cpuRdData` reads 0. A `cmdClear` pulse releases it to the SIE.
- R10: A `cmdRewind` pulse sets the CPU pointer back to byte 0. In receive, the data is then read again from the start. In transmit, later writes overwrite from byte 0 and `dataLen` keeps its highest value.
- R11: A `cpuRdEn` while the CPU does not own the buffer reads 0 and does not move the pointer. The next received packet is still read from byte 0.
- R12: `trnLoad` sets the target to `trnLoadVal`. While `trnEnable` is high, each received packet adds 1 to `trnCount`. `trnClear` sets `trnCount` to 0. `trnDone` is high when `trnEnable`=1, the target is not 0 and `trnCount` equals the target.
- R13: A change of `dirTx` resets the pointer and length on the next cycle. The CPU then owns the buffer in transmit, and the SIE owns it in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirTx | input | 1 | 1 = CPU writes (transmit), 0 = CPU reads (receive) |
| wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| contMode | input | 1 | 1 = hand over at full buffer, 0 = at maxPkt |
| maxPkt | input | 7 | Maximum packet size in bytes (0 or above 64 means 64) |
| rxAutoRelease | input | 1 | Release the receive buffer after full readout |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 16 | CPU write data |
| cpuRdEn | input | 1 | CPU read strobe, advances the pointer |
| cpuRdData | output | 16 | Data at the CPU pointer |
| cmdCommit | input | 1 | End the write and hand over the packet |
| cmdClear | input | 1 | Clear the CPU-side buffer |
| cmdRewind | input | 1 | Set the CPU pointer to 0 |
| cpuOwns | output | 1 | The CPU holds the buffer |
| dataLen | output | 7 | Byte count of the CPU-side packet |
| trnEnable | input | 1 | Enable the received-packet counter |
| trnLoad | input | 1 | Load the target count |
| trnLoadVal | input | 8 | Target count |
| trnClear | input | 1 | Clear the current count |
| trnCount | output | 8 | Received packets counted |
| trnDone | output | 1 | The count has reached the target |
| sieTxReady | output | 1 | A transmit packet is waiting for the SIE |
| sieTxLen | output | 7 | Length of the transmit packet |
| sieTxDone | input | 1 | The SIE has sent the packet |
| sieRdAddr | input | 6 | SIE byte read address |
| sieRdData | output | 8 | Byte at sieRdAddr |
| sieRxReady | output | 1 | The buffer is free for reception |
| sieRxWrEn | input | 1 | SIE byte write strobe |
| sieRxAddr | input | 6 | SIE byte write address |
| sieRxData | input | 8 | SIE byte write data |
| sieRxEnd | input | 1 | End of a received packet |
| sieRxLen | input | 7 | Length of the received packet |

## Verification
Transmit packets are built in four ways, and each one tells apart a different hand-over trigger. A mixed byte and word fill ended by commit shows the byte-lane order and the short-packet path. A word fill against a small maximum shows the non-continuous limit. A 32-word fill in continuous mode shows the capacity limit. A clear-then-commit sequence shows the zero-length case. Receive packets of five bytes, two bytes and zero bytes are read with 16-bit accesses and with rewinds. These separate the odd tail lane, automatic release against held release, and the zero-length release rule, while the packet counter is loaded, counted and cleared across them.

// File: rtl/usbPktPkg.sv
package usbPktPkg;
  localparam int BUF_BYTES = 64;
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int LEN_W = PTR_W + 1;

  typedef struct packed {
    logic             cpuWrLo;
    logic             cpuWrHi;
    logic [PTR_W-1:0] cpuAddr;
    logic             cpuRdLoOk;
    logic             cpuRdHiOk;
    logic             sieWr;
  } bufStrobe_t;
endpackage

// File: rtl/pkt_buf_data.sv
module pkt_buf_data import usbPktPkg::*; (
  input  logic             clk,
  input  bufStrobe_t       strb,
  input  logic [15:0]      cpuWrData,
  input  logic [PTR_W-1:0] sieRxAddr,
  input  logic [7:0]       sieRxData,
  input  logic [PTR_W-1:0] sieRdAddr,
  output logic [15:0]      cpuRdData,
  output logic [7:0]       sieRdData
);
  logic [7:0]       mem [BUF_BYTES];
  logic [PTR_W-1:0] laneAddr [2];
  logic [1:0]       laneOk;

  assign laneAddr[0] = strb.cpuAddr;
  assign laneAddr[1] = strb.cpuAddr + 1'b1;
  assign laneOk      = {strb.cpuRdHiOk, strb.cpuRdLoOk};

  always_ff @(posedge clk) begin
    if (strb.sieWr)   mem[sieRxAddr]   <= sieRxData;
    if (strb.cpuWrLo) mem[laneAddr[0]] <= cpuWrData[7:0];
    if (strb.cpuWrHi) mem[laneAddr[1]] <= cpuWrData[15:8];
  end

  for (genvar g = 0; g < 2; g++) begin : gLane
    assign cpuRdData[8*g +: 8] = laneOk[g] ? mem[laneAddr[g]] : 8'h00;
  end

  assign sieRdData = mem[sieRdAddr];
endmodule

// File: rtl/pkt_buf_ctrl.sv
module pkt_buf_ctrl import usbPktPkg::*; #(
  parameter int TRN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirTx,
  input  logic             wide,
  input  logic             contMode,
  input  logic [LEN_W-1:0] maxPkt,
  input  logic             rxAutoRelease,
  input  logic             cpuWrEn,
  input  logic             cpuRdEn,
  input  logic             cmdCommit,
  input  logic             cmdClear,
  input  logic             cmdRewind,
  input  logic             trnEnable,
  input  logic             trnLoad,
  input  logic [TRN_W-1:0] trnLoadVal,
  input  logic             trnClear,
  input  logic             sieTxDone,
  input  logic             sieRxWrEn,
  input  logic             sieRxEnd,
  input  logic [LEN_W-1:0] sieRxLen,
  output bufStrobe_t       strb,
  output logic             cpuOwns,
  output logic [LEN_W-1:0] dataLen,
  output logic             sieTxReady,
  output logic [LEN_W-1:0] sieTxLen,
  output logic             sieRxReady,
  output logic [TRN_W-1:0] trnCount,
  output logic             trnDone
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(BUF_BYTES);

  logic             ownQ, ownD, dirQ, dirD;
  logic [LEN_W-1:0] lenQ, lenD, ptrQ, ptrD;
  logic [TRN_W-1:0] cntQ, cntD, tgtQ, tgtD;

  logic             dirMatch, cpuHeld, rxView;
  logic [LEN_W-1:0] limit, ptrPlus1, newWrPtr, newRdPtr, rxLenClamped;
  logic             spaceLo, spaceHi, availLo, availHi, wrGo, rdGo;

  assign dirMatch = (dirTx == dirQ);
  assign cpuHeld  = dirMatch && ownQ;
  assign rxView   = cpuHeld && !dirTx;

  assign limit = contMode ? FULL
               : ((maxPkt == '0 || maxPkt > FULL) ? FULL : maxPkt);
  assign ptrPlus1 = ptrQ + LEN_W'(1);
  assign spaceLo  = ptrQ < limit;
  assign spaceHi  = wide && (ptrPlus1 < limit);
  assign availLo  = ptrQ < lenQ;
  assign availHi  = wide && (ptrPlus1 < lenQ);
  assign newWrPtr = ptrQ + (spaceHi ? LEN_W'(2) : LEN_W'(1));
  assign newRdPtr = ptrQ + (availHi ? LEN_W'(2) : LEN_W'(1));
  assign rxLenClamped = (sieRxLen > FULL) ? FULL : sieRxLen;

  assign wrGo = cpuHeld && dirTx && !cmdClear && !cmdCommit && !cmdRewind
              && cpuWrEn && spaceLo;
  assign rdGo = rxView && !cmdClear && !cmdRewind && cpuRdEn && availLo;

  always_comb begin
    strb.cpuWrLo   = wrGo;
    strb.cpuWrHi   = wrGo && spaceHi;
    strb.cpuAddr   = ptrQ[PTR_W-1:0];
    strb.cpuRdLoOk = rxView && availLo;
    strb.cpuRdHiOk = rxView && availHi;
    strb.sieWr     = dirMatch && !ownQ && !dirTx && sieRxWrEn;
  end

  always_comb begin
    ownD = ownQ; lenD = lenQ; ptrD = ptrQ; dirD = dirQ;
    cntD = cntQ; tgtD = tgtQ;
    if (trnLoad)  tgtD = trnLoadVal;
    if (trnClear) cntD = '0;
    if (!dirMatch) begin
      dirD = dirTx; ownD = dirTx; lenD = '0; ptrD = '0;
    end else if (ownQ) begin
      if (cmdClear) begin
        lenD = '0; ptrD = '0;
        if (!dirTx) ownD = 1'b0;
      end else if (cmdCommit && dirTx) begin
        ownD = 1'b0; ptrD = '0;
      end else if (cmdRewind) begin
        ptrD = '0;
      end else if (wrGo) begin
        ptrD = newWrPtr;
        lenD = (newWrPtr > lenQ) ? newWrPtr : lenQ;
        if (newWrPtr >= limit) begin
          ownD = 1'b0; ptrD = '0;
        end
      end else if (rdGo) begin
        if (newRdPtr >= lenQ && rxAutoRelease) begin
          ownD = 1'b0; lenD = '0; ptrD = '0;
        end else begin
          ptrD = newRdPtr;
        end
      end
    end else begin
      if (dirTx && sieTxDone) begin
        ownD = 1'b1; lenD = '0; ptrD = '0;
      end
      if (!dirTx && sieRxEnd) begin
        ownD = 1'b1; lenD = rxLenClamped; ptrD = '0;
        if (trnEnable && !trnClear) cntD = cntQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownQ <= 1'b1; dirQ <= 1'b1; lenQ <= '0; ptrQ <= '0;
      cntQ <= '0;   tgtQ <= '0;
    end else begin
      ownQ <= ownD; dirQ <= dirD; lenQ <= lenD; ptrQ <= ptrD;
      cntQ <= cntD; tgtQ <= tgtD;
    end
  end

  assign cpuOwns    = ownQ;
  assign dataLen    = lenQ;
  assign sieTxLen   = lenQ;
  assign sieTxReady = dirMatch && !ownQ && dirQ;
  assign sieRxReady = dirMatch && !ownQ && !dirQ;
  assign trnCount   = cntQ;
  assign trnDone    = trnEnable && (tgtQ != '0) && (cntQ == tgtQ);

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    dataLen <= FULL); // R3
  AST_COMMIT_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (ownQ && dirQ && dirTx && cmdCommit && !cmdClear)
      |=> (!cpuOwns && sieTxReady)); // R4
  AST_TXDONE_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (!ownQ && dirQ && dirTx && sieTxDone)
      |=> (cpuOwns && dataLen == '0)); // R6
  AST_ZLP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ownQ && !dirQ && !dirTx && lenQ == '0 && !cmdClear) |=> cpuOwns); // R9
  AST_TRN_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    trnClear |=> (trnCount == '0)); // R12
endmodule

// File: rtl/pkt_buf_port.sv
module pkt_buf_port import usbPktPkg::*; #(
  parameter int TRN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirTx,
  input  logic             wide,
  input  logic             contMode,
  input  logic [LEN_W-1:0] maxPkt,
  input  logic             rxAutoRelease,
  input  logic             cpuWrEn,
  input  logic [15:0]      cpuWrData,
  input  logic             cpuRdEn,
  output logic [15:0]      cpuRdData,
  input  logic             cmdCommit,
  input  logic             cmdClear,
  input  logic             cmdRewind,
  output logic             cpuOwns,
  output logic [LEN_W-1:0] dataLen,
  input  logic             trnEnable,
  input  logic             trnLoad,
  input  logic [TRN_W-1:0] trnLoadVal,
  input  logic             trnClear,
  output logic [TRN_W-1:0] trnCount,
  output logic             trnDone,
  output logic             sieTxReady,
  output logic [LEN_W-1:0] sieTxLen,
  input  logic             sieTxDone,
  input  logic [PTR_W-1:0] sieRdAddr,
  output logic [7:0]       sieRdData,
  output logic             sieRxReady,
  input  logic             sieRxWrEn,
  input  logic [PTR_W-1:0] sieRxAddr,
  input  logic [7:0]       sieRxData,
  input  logic             sieRxEnd,
  input  logic [LEN_W-1:0] sieRxLen
);
  bufStrobe_t strb;

  pkt_buf_ctrl #(.TRN_W(TRN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .wide(wide), .contMode(contMode),
    .maxPkt(maxPkt), .rxAutoRelease(rxAutoRelease), .cpuWrEn(cpuWrEn),
    .cpuRdEn(cpuRdEn), .cmdCommit(cmdCommit), .cmdClear(cmdClear),
    .cmdRewind(cmdRewind), .trnEnable(trnEnable), .trnLoad(trnLoad),
    .trnLoadVal(trnLoadVal), .trnClear(trnClear), .sieTxDone(sieTxDone),
    .sieRxWrEn(sieRxWrEn), .sieRxEnd(sieRxEnd), .sieRxLen(sieRxLen),
    .strb(strb), .cpuOwns(cpuOwns), .dataLen(dataLen),
    .sieTxReady(sieTxReady), .sieTxLen(sieTxLen), .sieRxReady(sieRxReady),
    .trnCount(trnCount), .trnDone(trnDone)
  );

  pkt_buf_data uData (
    .clk(clk), .strb(strb), .cpuWrData(cpuWrData), .sieRxAddr(sieRxAddr),
    .sieRxData(sieRxData), .sieRdAddr(sieRdAddr), .cpuRdData(cpuRdData),
    .sieRdData(sieRdData)
  );
endmodule

// File: tb/pkt_buf_port_test.sv
module pkt_buf_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirTx = 1'b1, wide = 1'b0, contMode = 1'b1, rxAutoRelease = 1'b1;
  logic [6:0] maxPkt = 7'd0;
  logic cpuWrEn = 0, cpuRdEn = 0, cmdCommit = 0, cmdClear = 0, cmdRewind = 0;
  logic [15:0] cpuWrData = '0;
  logic trnEnable = 0, trnLoad = 0, trnClear = 0;
  logic [7:0] trnLoadVal = '0;
  logic sieTxDone = 0, sieRxWrEn = 0, sieRxEnd = 0;
  logic [5:0] sieRdAddr = '0, sieRxAddr = '0;
  logic [7:0] sieRxData = '0;
  logic [6:0] sieRxLen = '0;
  logic [15:0] cpuRdData;
  logic cpuOwns, trnDone, sieTxReady, sieRxReady;
  logic [6:0] dataLen, sieTxLen;
  logic [7:0] trnCount, sieRdData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  pkt_buf_port uut (.*);

  // behavioural reference model
  logic [7:0] mBuf [64];
  int  mLen, mPtr, mTgt;
  bit  mOwn, mDir;
  logic [7:0] mCnt;

  initial for (int i = 0; i < 64; i++) mBuf[i] = 8'h00;

  always @(posedge clk) begin
    int lim;
    if (!rstN) begin
      mOwn = 1; mDir = 1; mLen = 0; mPtr = 0; mCnt = 0; mTgt = 0;
    end else begin
      lim = contMode ? 64 : ((maxPkt == 0 || maxPkt > 64) ? 64 : int'(maxPkt));
      if (trnLoad) mTgt = trnLoadVal;
      if (trnClear) mCnt = 0;
      if (dirTx != mDir) begin
        mDir = dirTx; mOwn = dirTx; mLen = 0; mPtr = 0;
      end else if (mOwn) begin
        if (cmdClear) begin
          mLen = 0; mPtr = 0;
          if (!dirTx) mOwn = 0;
        end else if (cmdCommit && dirTx) begin
          mOwn = 0; mPtr = 0;
        end else if (cmdRewind) begin
          mPtr = 0;
        end else if (dirTx && cpuWrEn && mPtr < lim) begin
          mBuf[mPtr] = cpuWrData[7:0]; mPtr++;
          if (wide && mPtr < lim) begin mBuf[mPtr] = cpuWrData[15:8]; mPtr++; end
          if (mPtr > mLen) mLen = mPtr;
          if (mPtr >= lim) begin mOwn = 0; mPtr = 0; end
        end else if (!dirTx && cpuRdEn && mPtr < mLen) begin
          mPtr += (wide && mPtr + 1 < mLen) ? 2 : 1;
          if (mPtr >= mLen && rxAutoRelease) begin mOwn = 0; mLen = 0; mPtr = 0; end
        end
      end else begin
        if (!dirTx && sieRxWrEn) mBuf[sieRxAddr] = sieRxData;
        if (dirTx && sieTxDone) begin mOwn = 1; mLen = 0; end
        if (!dirTx && sieRxEnd) begin
          mOwn = 1; mLen = (sieRxLen > 64) ? 64 : int'(sieRxLen); mPtr = 0;
          if (trnEnable && !trnClear) mCnt = mCnt + 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit match, expTx, expRx;
      logic [7:0] lo, hi;
      match = (dirTx == mDir);
      expTx = !mOwn && mDir && match;
      expRx = !mOwn && !mDir && match;
      lo = 8'h00; hi = 8'h00;
      if (mOwn && match && !dirTx) begin
        if (mPtr < mLen) lo = mBuf[mPtr];
        if (wide && mPtr + 1 < mLen) hi = mBuf[mPtr + 1];
      end
      chk(curReq, "cpuOwns", 32'(cpuOwns), 32'(mOwn));
      chk(curReq, "dataLen", 32'(dataLen), 32'(mLen));
      chk(curReq, "sieTxReady", 32'(sieTxReady), 32'(expTx));
      chk(curReq, "sieRxReady", 32'(sieRxReady), 32'(expRx));
      chk(curReq, "cpuRdData", 32'(cpuRdData), 32'({hi, lo}));
      chk(curReq, "trnCount", 32'(trnCount), 32'(mCnt));
      chk(curReq, "trnDone", 32'(trnDone),
          32'(trnEnable && mTgt != 0 && int'(mCnt) == mTgt));
      if (expTx) begin
        chk(curReq, "sieTxLen", 32'(sieTxLen), 32'(mLen));
        chk(curReq, "sieRdData", 32'(sieRdData), 32'(mBuf[sieRdAddr]));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cpuWrEn = 0; cpuRdEn = 0; cmdCommit = 0; cmdClear = 0; cmdRewind = 0;
    trnLoad = 0; trnClear = 0; sieTxDone = 0; sieRxWrEn = 0; sieRxEnd = 0;
  endtask

  task automatic settle();
    step(); @(negedge clk);
  endtask

  task automatic wr(logic w, logic [15:0] d);
    wide = w; cpuWrEn = 1; cpuWrData = d; step();
  endtask

  task automatic sieByte(logic [5:0] a, logic [7:0] d);
    sieRxWrEn = 1; sieRxAddr = a; sieRxData = d; step();
  endtask

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    curReq = "R1";
    chk("R1", "cpuOwns", 32'(cpuOwns), 1);
    chk("R1", "dataLen", 32'(dataLen), 0);
    chk("R1", "sieTxReady", 32'(sieTxReady), 0);
    chk("R1", "trnCount", 32'(trnCount), 0);
    step();

    // mixed byte/word fill, commit
    curReq = "R2";
    wr(0, 16'h0011); wr(0, 16'h0022); wr(0, 16'h0033); wr(1, 16'h5544);
    @(negedge clk);
    chk("R2", "dataLen", 32'(dataLen), 5);
    curReq = "R4";
    cmdCommit = 1; sieRdAddr = 6'd3; settle();
    chk("R4", "sieTxLen", 32'(sieTxLen), 5);
    chk("R2", "sieRdData lane order", 32'(sieRdData), 32'h44);
    sieRdAddr = 6'd4; settle();
    chk("R6", "sieRdData", 32'(sieRdData), 32'h55);
    curReq = "R6";
    sieTxDone = 1; settle();
    chk("R6", "cpuOwns", 32'(cpuOwns), 1);
    chk("R6", "dataLen", 32'(dataLen), 0);

    // non-continuous limit
    curReq = "R3";
    contMode = 0; maxPkt = 7'd8;
    wr(1, 16'h0201); wr(1, 16'h0403); wr(1, 16'h0605);
    @(negedge clk);
    chk("R3", "cpuOwns before limit", 32'(cpuOwns), 1);
    wr(1, 16'h0807);
    @(negedge clk);
    chk("R3", "sieTxReady at maxPkt", 32'(sieTxReady), 1);
    chk("R3", "sieTxLen", 32'(sieTxLen), 8);
    sieTxDone = 1; step();

    // capacity limit
    contMode = 1;
    for (int i = 0; i < 32; i++) wr(1, 16'(i * 16'h0101));
    @(negedge clk);
    chk("R3", "sieTxLen at capacity", 32'(sieTxLen), 64);
    chk("R3", "cpuOwns at capacity", 32'(cpuOwns), 0);
    sieTxDone = 1; step();

    // zero-length transmit
    curReq = "R5";
    wr(0, 16'h00E1); wr(0, 16'h00E2);
    cmdClear = 1; settle();
    chk("R5", "dataLen after clear", 32'(dataLen), 0);
    chk("R5", "cpuOwns after clear", 32'(cpuOwns), 1);
    cmdCommit = 1; sieRdAddr = 6'd0; settle();
    chk("R5", "sieTxReady", 32'(sieTxReady), 1);
    chk("R5", "sieTxLen", 32'(sieTxLen), 0);
    sieTxDone = 1; step();

    // transmit rewind
    curReq = "R10";
    wr(0, 16'h00AA); wr(0, 16'h00BB); wr(0, 16'h00CC);
    cmdRewind = 1; step();
    wr(0, 16'h00DD);
    @(negedge clk);
    chk("R10", "dataLen kept", 32'(dataLen), 3);
    cmdCommit = 1; sieRdAddr = 6'd0; settle();
    chk("R10", "rewritten byte", 32'(sieRdData), 32'hDD);
    sieRdAddr = 6'd1; settle();
    chk("R10", "untouched byte", 32'(sieRdData), 32'hBB);
    sieTxDone = 1; step();

    // switch to receive
    curReq = "R13";
    dirTx = 0; settle();
    chk("R13", "sieRxReady", 32'(sieRxReady), 1);
    chk("R13", "cpuOwns", 32'(cpuOwns), 0);
    curReq = "R11";
    wide = 1; cpuRdEn = 1; settle();
    chk("R11", "cpuRdData idle", 32'(cpuRdData), 0);
    trnLoad = 1; trnLoadVal = 8'd2; trnEnable = 1; step();

    // five-byte receive packet
    curReq = "R7";
    for (int i = 0; i < 5; i++) sieByte(6'(i), 8'(8'hA0 + i));
    sieRxEnd = 1; sieRxLen = 7'd5; settle();
    chk("R7", "dataLen", 32'(dataLen), 5);
    chk("R11", "pointer unmoved", 32'(cpuRdData), 32'hA1A0);
    cpuRdEn = 1; settle();
    chk("R7", "second word", 32'(cpuRdData), 32'hA3A2);
    curReq = "R10";
    cmdRewind = 1; settle();
    chk("R10", "re-read", 32'(cpuRdData), 32'hA1A0);
    curReq = "R7";
    cpuRdEn = 1; step(); cpuRdEn = 1; settle();
    chk("R7", "odd tail", 32'(cpuRdData), 32'h00A4);
    curReq = "R8";
    cpuRdEn = 1; settle();
    chk("R8", "auto release", 32'(sieRxReady), 1);
    chk("R12", "trnCount", 32'(trnCount), 1);

    // held release
    rxAutoRelease = 0;
    sieByte(6'd0, 8'hB0); sieByte(6'd1, 8'hB1);
    sieRxEnd = 1; sieRxLen = 7'd2; step();
    cpuRdEn = 1; settle();
    chk("R8", "held after readout", 32'(cpuOwns), 1);
    chk("R8", "no data past end", 32'(cpuRdData), 0);
    cmdRewind = 1; settle();
    chk("R10", "re-read held", 32'(cpuRdData), 32'hB1B0);
    cmdClear = 1; settle();
    chk("R8", "released by clear", 32'(cpuOwns), 0);
    curReq = "R12";
    chk("R12", "trnCount", 32'(trnCount), 2);
    chk("R12", "trnDone", 32'(trnDone), 1);
    trnClear = 1; settle();
    chk("R12", "trnCount cleared", 32'(trnCount), 0);
    chk("R12", "trnDone cleared", 32'(trnDone), 0);

    // zero-length receive
    curReq = "R9";
    sieRxEnd = 1; sieRxLen = 7'd0; settle();
    chk("R9", "cpuOwns", 32'(cpuOwns), 1);
    rxAutoRelease = 1; cpuRdEn = 1; settle();
    chk("R9", "held after read", 32'(cpuOwns), 1);
    chk("R9", "cpuRdData", 32'(cpuRdData), 0);
    cmdClear = 1; settle();
    chk("R9", "released", 32'(sieRxReady), 1);

    // back to transmit
    curReq = "R13";
    dirTx = 1; settle();
    chk("R13", "cpuOwns tx", 32'(cpuOwns), 1);
    chk("R13", "dataLen tx", 32'(dataLen), 0);
    step();
    summary();
  end
endmodule